// File: doc/BRIEF.md
# Double-to-Single Narrowing with Half-Precision Tie Preservation

This block narrows an IEEE binary64 operand to binary32 with round-to-nearest-even. It then optionally adjusts two low bits of the binary32 result so that a later binary32-to-binary16 nearest-even rounding lands on the same half-precision value as a direct binary64-to-binary16 rounding would. Without the adjustment, the second rounding can see a false tie, or lose a tie-breaking bit, and be off by one unit in the last place. In the worst case it can carry into infinity.

The adjustment looks only at the original 64-bit pattern. Any set bit below the half-precision tie position forces the binary32 least significant bit to one. A clear half-precision tie bit in the operand forces the matching binary32 bit (bit 12) to zero. A one-bit mode input chooses between the adjusted result (for a nearest-even consumer) and the plain narrowed result (for a toward-zero consumer). Operands travel with a valid strobe through a single register stage.

Top module: `d2s_narrow_tiefix`

## Requirements
- R1: `out_valid` equals the previous cycle's `in_valid`. When `in_valid` is low, `out_bits` holds its previous value whatever `in_bits` and `in_mode` carry.
- R2: During reset and on the first cycle after it, `out_valid` is 0 and `out_bits` is 32'h0000_0000.
- R3: For a biased binary64 exponent e in 897..1150, the result has exponent e-896 and mantissa `in_bits[51:29]`. It is rounded to nearest-even with `in_bits[28]` as guard and `in_bits[27:0]` as sticky, and keeps the sign bit `in_bits[63]`. With `in_mode`=1 (toward-zero consumer) this plain result is output unchanged.
- R4: An exponent of 1151..2046, or a rounding carry that reaches exponent 255, gives signed infinity ({sign, 8'hFF, 23'h0}) in both modes. No low-bit adjustment is applied.
- R5: A binary64 infinity (exponent 2047, mantissa 0) gives a binary32 infinity of the same sign.
- R6: A binary64 NaN (exponent 2047, mantissa nonzero) gives {sign, 31'h7FC0_0000}: exponent all ones, bit 22 set, other mantissa bits clear.
- R7: An exponent of 896 or less gives a zero of the same sign in both modes.
- R8: With `in_mode`=0 and a finite result from the R3 range, bit 0 of the result is forced to 1 when any of `in_bits[40:0]` is set.
- R9: With `in_mode`=0 and a finite result from the R3 range, bit 12 of the result is forced to 0 when `in_bits[41]` is clear, and is left as rounded when it is set. The clear is applied after the R8 forcing.
- R10: With `in_mode`=0, operand 64'h40EE_6A00_0000_0001 gives 32'h4773_5001 (which half-rounds to 16'h7B9B), and operand 64'h40EF_FDFF_FFFF_FFFF gives 32'h477F_E001 (which half-rounds to 16'h7BFF, not infinity).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_mode | input | 1 | 0: apply nearest-even tie adjustment; 1: plain narrowed result |
| in_bits | input | 64 | binary64 operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_bits | output | 32 | binary32 result |

## Verification
Every result is due exactly one clock after its operand is accepted. The driver applies operands on falling edges and pushes the hand-computed word into a queue. The monitor samples on the following falling edge: it pops and compares on each `out_valid` and, on idle cycles, checks that the held word is unchanged while `in_bits` is scrambled. The expected words were worked out by hand from the rounding, the special-case and the adjustment requirements. They cover tie-to-even and tie-to-odd operands, carries into bit 12 and into infinity, the exponent boundaries 896/897 and 1150/1151, and both modes on the same operand.

// File: rtl/d2s_pkg.sv
package d2s_pkg;
    parameter int WIDE_W   = 64;
    parameter int WIDE_EXP = 11;
    parameter int WIDE_MAN = 52;
    parameter int NAR_W    = 32;
    parameter int NAR_EXP  = 8;
    parameter int NAR_MAN  = 23;
    parameter int HALF_MAN = 10;

    localparam int BIAS_DELTA = (1 << (WIDE_EXP - 1)) - (1 << (NAR_EXP - 1));
    localparam int DROP       = WIDE_MAN - NAR_MAN;
    localparam int WIDE_TIE   = WIDE_MAN - HALF_MAN - 1;
    localparam int NAR_TIE    = NAR_MAN - HALF_MAN - 1;

    typedef enum logic {
        RND_NEAREST = 1'b0,
        RND_ZERO    = 1'b1
    } fix_mode_e;

    typedef struct packed {
        logic             valid;
        logic [NAR_W-1:0] bits;
    } stage_t;
endpackage

// File: rtl/d2s_round.sv
module d2s_round
    import d2s_pkg::*;
(
    input  logic [WIDE_W-1:0] wide_i,
    output logic [NAR_W-1:0]  nar_o,
    output logic              normal_o
);
    localparam logic [WIDE_EXP-1:0] EXP_ALL = '1;
    localparam logic [WIDE_EXP-1:0] EXP_LO  = WIDE_EXP'(BIAS_DELTA);
    localparam logic [WIDE_EXP-1:0] EXP_HI  = WIDE_EXP'(BIAS_DELTA + (1 << NAR_EXP) - 1);
    localparam logic [NAR_EXP-1:0]  NEXP_ALL = '1;

    logic                 sign;
    logic [WIDE_EXP-1:0]  exp_w;
    logic [WIDE_MAN-1:0]  man_w;
    logic [WIDE_EXP-1:0]  exp_diff;
    logic [NAR_MAN-1:0]   keep;
    logic                 guard;
    logic                 sticky;
    logic                 rnd_up;
    logic [NAR_W-1:0]     sum;

    always_comb begin
        sign     = wide_i[WIDE_W-1];
        exp_w    = wide_i[WIDE_W-2 -: WIDE_EXP];
        man_w    = wide_i[WIDE_MAN-1:0];
        exp_diff = exp_w - EXP_LO;
        keep     = man_w[WIDE_MAN-1 -: NAR_MAN];
        guard    = man_w[DROP-1];
        sticky   = |man_w[DROP-2:0];
        rnd_up   = guard & (sticky | keep[0]);
        sum      = {1'b0, exp_diff[NAR_EXP-1:0], keep} + NAR_W'(rnd_up);

        nar_o    = '0;
        normal_o = 1'b0;
        if (exp_w == EXP_ALL) begin
            if (man_w != '0)
                nar_o = {sign, NEXP_ALL, 1'b1, {(NAR_MAN-1){1'b0}}};
            else
                nar_o = {sign, NEXP_ALL, {NAR_MAN{1'b0}}};
        end else if (exp_w >= EXP_HI) begin
            nar_o = {sign, NEXP_ALL, {NAR_MAN{1'b0}}};
        end else if (exp_w <= EXP_LO) begin
            nar_o = {sign, {(NAR_W-1){1'b0}}};
        end else begin
            nar_o    = {sign, sum[NAR_W-2:0]};
            normal_o = (sum[NAR_W-2 -: NAR_EXP] != NEXP_ALL);
        end
    end
endmodule

// File: rtl/d2s_tiefix.sv
module d2s_tiefix
    import d2s_pkg::*;
(
    input  logic [NAR_W-1:0]  nar_i,
    input  logic [WIDE_TIE:0] wide_low_i,
    input  logic              apply_i,
    output logic [NAR_W-1:0]  nar_o
);
    always_comb begin
        nar_o = nar_i;
        if (apply_i) begin
            // sticky first, then tie clear
            nar_o[0] = nar_o[0] | (|wide_low_i[WIDE_TIE-1:0]);
            if (!wide_low_i[WIDE_TIE])
                nar_o[NAR_TIE] = 1'b0;
        end
    end
endmodule

// File: rtl/d2s_narrow_tiefix.sv
module d2s_narrow_tiefix
    import d2s_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_mode,
    input  logic [WIDE_W-1:0] in_bits,
    output logic              out_valid,
    output logic [NAR_W-1:0]  out_bits
);
    localparam logic [WIDE_EXP-1:0] EXP_ALL = '1;
    localparam logic [WIDE_EXP-1:0] EXP_LO  = WIDE_EXP'(BIAS_DELTA);
    localparam logic [WIDE_EXP-1:0] EXP_HI  = WIDE_EXP'(BIAS_DELTA + (1 << NAR_EXP) - 1);

    logic [NAR_W-1:0] nar_plain;
    logic             nar_normal;
    logic             fix_apply;
    logic [NAR_W-1:0] nar_fixed;
    stage_t           stage_d, stage_q;

    d2s_round u_round (
        .wide_i   (in_bits),
        .nar_o    (nar_plain),
        .normal_o (nar_normal)
    );

    assign fix_apply = (fix_mode_e'(in_mode) == RND_NEAREST) && nar_normal;

    d2s_tiefix u_fix (
        .nar_i      (nar_plain),
        .wide_low_i (in_bits[WIDE_TIE:0]),
        .apply_i    (fix_apply),
        .nar_o      (nar_fixed)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        if (in_valid)
            stage_d.bits = nar_fixed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stage_q <= '0;
        else
            stage_q <= stage_d;
    end

    assign out_valid = stage_q.valid;
    assign out_bits  = stage_q.bits;

    logic [WIDE_EXP-1:0] in_exp;
    logic                in_man_nz;
    assign in_exp    = in_bits[WIDE_W-2 -: WIDE_EXP];
    assign in_man_nz = |in_bits[WIDE_MAN-1:0];

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_bits)));
    a_r6_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_exp == EXP_ALL && in_man_nz)
        |=> (out_bits[NAR_W-2:0] == {{NAR_EXP{1'b1}}, 1'b1, {(NAR_MAN-1){1'b0}}}));
    a_r5_inf_signed: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_exp == EXP_ALL && !in_man_nz)
        |=> (out_bits == {$past(in_bits[WIDE_W-1]), {NAR_EXP{1'b1}}, {NAR_MAN{1'b0}}}));
    a_r7_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_exp <= EXP_LO)
        |=> (out_bits[NAR_W-2:0] == '0));
    a_r8_sticky_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode && in_exp > EXP_LO && in_exp < EXP_HI
         && (|in_bits[WIDE_TIE-1:0]))
        |=> (out_bits[0] || out_bits[NAR_W-2 -: NAR_EXP] == {NAR_EXP{1'b1}}));
    a_r9_tie_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode && in_exp > EXP_LO && in_exp < EXP_HI
         && !in_bits[WIDE_TIE])
        |=> (!out_bits[NAR_TIE] || out_bits[NAR_W-2 -: NAR_EXP] == {NAR_EXP{1'b1}}));
endmodule

// File: tb/sim_d2s_narrow_tiefix.sv
module sim_d2s_narrow_tiefix;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic [63:0] in_bits = '0;
    logic        out_valid;
    logic [31:0] out_bits;

    always #2 clk = ~clk;

    d2s_narrow_tiefix u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_bits(in_bits), .out_valid(out_valid), .out_bits(out_bits)
    );

    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_out = '0;
    bit          drive_done = 0;
    bit          finished = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic send(input logic [63:0] v, input logic m, input logic [31:0] e, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_bits  = v;
        in_mode  = m;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_bits  = {$urandom, $urandom};
            in_mode  = 1'(i);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !finished) begin
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R1 unexpected out_valid", {31'b0, out_valid}, 32'h0);
                    end else begin
                        logic [31:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(out_bits === e, t, out_bits, e);
                    end
                    last_out = out_bits;
                end else begin
                    check(out_bits === last_out, "R1 hold while idle", out_bits, last_out);
                    check(exp_q.size() == 0 || in_valid, "R1 result late", {31'b0, out_valid}, 32'h1);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 32'h0, 32'h1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R2 reset valid", {31'b0, out_valid}, 32'h0);
        check(out_bits === 32'h0, "R2 reset data", out_bits, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R2 first cycle valid", {31'b0, out_valid}, 32'h0);
        check(out_bits === 32'h0, "R2 first cycle data", out_bits, 32'h0);

        send(64'h40EE_6A00_0000_0001, 1'b0, 32'h4773_5001, "R10 tie-up kept");
        send(64'h40EE_6A00_0000_0001, 1'b1, 32'h4773_5000, "R3 pass-through of R10 operand");
        idle(2);
        send(64'h40EF_FDFF_FFFF_FFFF, 1'b0, 32'h477F_E001, "R10 no false tie to inf");
        send(64'h40EF_FDFF_FFFF_FFFF, 1'b1, 32'h477F_F000, "R3 plain rounding up");
        send(64'h3FF0_0000_0000_0000, 1'b0, 32'h3F80_0000, "R3 one");
        send(64'hBFF0_0000_0000_0000, 1'b1, 32'hBF80_0000, "R3 minus one");
        idle(1);
        send(64'h3FF0_0000_1000_0000, 1'b1, 32'h3F80_0000, "R3 tie to even stays");
        send(64'h3FF0_0000_3000_0000, 1'b1, 32'h3F80_0002, "R3 tie to even rounds up");
        send(64'h3FF0_0000_1000_0000, 1'b0, 32'h3F80_0001, "R8 sticky lsb forced");
        send(64'h3FF0_01FF_F000_0000, 1'b1, 32'h3F80_1000, "R3 carry into bit 12");
        send(64'h3FF0_01FF_F000_0000, 1'b0, 32'h3F80_0001, "R9 bit 12 cleared after R8");
        idle(3);
        send(64'h7FF0_0000_0000_0000, 1'b0, 32'h7F80_0000, "R5 plus inf");
        send(64'hFFF0_0000_0000_0000, 1'b1, 32'hFF80_0000, "R5 minus inf");
        send(64'h7FF0_0000_0000_0001, 1'b0, 32'h7FC0_0000, "R6 nan quiet");
        send(64'hFFF8_0000_0000_0000, 1'b1, 32'hFFC0_0000, "R6 negative nan");
        send(64'h47F0_0000_0000_0000, 1'b0, 32'h7F80_0000, "R4 exponent overflow");
        send(64'hC7EF_FFFF_F000_0001, 1'b0, 32'hFF80_0000, "R4 rounding carry to inf");
        send(64'h47EF_FFFF_E000_0000, 1'b0, 32'h7F7F_FFFF, "R3 largest finite");
        idle(1);
        send(64'h3800_0000_0000_0000, 1'b0, 32'h0000_0000, "R7 exponent 896 flush");
        send(64'hB7F0_0000_0000_0123, 1'b0, 32'h8000_0000, "R7 negative flush");
        send(64'h3810_0000_0000_0000, 1'b1, 32'h0080_0000, "R3 smallest normal");
        send(64'h0000_0000_0000_0000, 1'b0, 32'h0000_0000, "R7 zero");
        idle(4);
        drive_done = 1;
        check(exp_q.size() == 0, "R1 all results delivered", exp_q.size(), 32'h0);
        finish_run();
    end
endmodule